// File: doc/BRIEF.md
# Cascaded Dual-Rate PI Regulator

This block closes two nested fixed-point control loops for a switching converter. The outer loop compares a voltage setpoint with the sampled output voltage. Its clamped result becomes the setpoint for the inner loop. The inner loop compares that setpoint with the sampled inductor current and produces a clamped duty command. Each loop is a proportional-integral compensator. When the output is clamped, a correction path feeds the clamp error back into the integrator.

The inner loop updates on every sample strobe. The outer loop updates on the first strobe after reset and then once every `DEC` strobes (8 by default). Between its updates the outer result is held. All gains arrive pre-scaled in signed Q format with `F` fraction bits (Q16 by default), with the integral gain already multiplied by that loop's own sample period. All data and limits are signed `W`-bit values (32 by default).

Top module: `cpi_cascade`

## Requirements
- R1: A synchronous reset forces `duty` to 0 and `duty_vld` low, and clears both integrators, the held outer result and the decimation count. The first update after reset therefore behaves as if no sample had come before it.
- R2: A strobe sampled high at clock edge E0 updates the outer loop at E0 when that loop is due, and captures `i_fb` at E0. The inner loop then updates at E1, and `duty_vld` is high for exactly the one cycle after E1.
- R3: Each loop's error is setpoint minus feedback. The proportional term is Kp times the error: the full product, plus 2^(F-1), arithmetic-shifted right by F (rounding half up).
- R4: The integrator is a unit delay. The output of update n adds the proportional term to the integrator value left by update n-1. The integrator then adds Ki times the error, rounded as in R3.
- R5: Each loop's output is its unclamped sum limited to the range [lo, hi] (`v_lo`/`v_hi` for the outer loop, `i_lo`/`i_hi` for the inner loop).
- R6: On every update, each integrator also adds Kc times (clamped output minus unclamped sum). This limits windup while the output is clamped.
- R7: The outer loop updates on the 1st, 9th, 17th, ... strobe after reset (every `DEC` strobes). Its result is held unchanged between those updates.
- R8: The inner loop's setpoint is the held, clamped outer result. Voltage inputs that change between outer updates have no effect on `duty`.
- R9: Every difference, sum and rounded product saturates to the signed W-bit range [-2^(W-1), 2^(W-1)-1] and never wraps.
- R10: `duty` holds its value whenever `duty_vld` is low, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| v_ref | input | W | Voltage setpoint, signed |
| v_fb | input | W | Sampled output voltage, signed |
| i_fb | input | W | Sampled inductor current, signed |
| v_kp | input | W | Outer proportional gain, signed Q(F) |
| v_ki | input | W | Outer integral gain times sample period, signed Q(F) |
| v_kc | input | W | Outer anti-windup gain, signed Q(F) |
| v_lo | input | W | Outer output lower limit |
| v_hi | input | W | Outer output upper limit |
| i_kp | input | W | Inner proportional gain, signed Q(F) |
| i_ki | input | W | Inner integral gain times sample period, signed Q(F) |
| i_kc | input | W | Inner anti-windup gain, signed Q(F) |
| i_lo | input | W | Duty lower limit |
| i_hi | input | W | Duty upper limit |
| duty | output | W | Clamped duty command, signed |
| duty_vld | output | 1 | One-cycle pulse marking a new duty value |

## Verification
A corrupted inner integrator shows up in `duty` on the very next valid pulse, because it enters the output with no filtering. A corrupted outer integrator or held setpoint is hidden until the next outer update, up to `DEC` strobes later, unless the proportional path exposes the held value directly. The bench therefore runs the inner loop as a pure proportional stage in the decimation tests, so each held setpoint appears one-for-one in `duty`. A wrong decimation count shows up as a `duty` step on a strobe where the setpoint should have stayed unchanged.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
   localparam int unsigned CPI_W_DFLT   = 32;
   localparam int unsigned CPI_F_DFLT   = 16;
   localparam int unsigned CPI_DEC_DFLT = 8;
   localparam bit          CPI_RND_DFLT = 1'b1;
endpackage

// File: rtl/cpi_qmul.sv
// Q-format product: rounds (or truncates) back to F fraction bits, saturates to W bits.
module cpi_qmul #(
   parameter int unsigned AW    = 32,
   parameter int unsigned BW    = 32,
   parameter int unsigned W     = 32,
   parameter int unsigned F     = 16,
   parameter bit          ROUND = 1'b1
) (
   input  logic signed [AW-1:0] a,
   input  logic signed [BW-1:0] b,
   output logic signed [W-1:0]  p
);
   localparam int unsigned PW = AW + BW + 1;
   localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (W-1)) - PW'(1);
   localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

   logic signed [PW-1:0] prod, adj, shf;

   assign prod = PW'(a) * PW'(b);

   generate
      if (ROUND) begin : g_round
         assign adj = prod + (PW'(1) <<< (F-1));
      end else begin : g_trunc
         assign adj = prod;
      end
   endgenerate

   assign shf = adj >>> F;

   always_comb begin
      if (shf > MAXV)      p = MAXV[W-1:0];
      else if (shf < MINV) p = MINV[W-1:0];
      else                 p = shf[W-1:0];
   end
endmodule

// File: rtl/cpi_decim.sv
// Strobe decimator: fires on the first strobe and every DEC-th one after it.
module cpi_decim #(
   parameter int unsigned DEC = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic stb,
   output logic fire
);
   localparam int unsigned CW = (DEC > 2) ? $clog2(DEC) : 1;
   localparam logic [CW-1:0] LAST = CW'(DEC - 1);

   logic [CW-1:0] cnt;

   assign fire = stb && (cnt == '0);

   generate
      if ((1 << CW) == DEC) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst)      cnt <= '0;
            else if (stb) cnt <= cnt + CW'(1);
         end
      end else begin : g_mod
         always_ff @(posedge clk) begin
            if (rst)      cnt <= '0;
            else if (stb) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
         end
      end
   endgenerate
endmodule

// File: rtl/cpi_pi.sv
// One PI stage with clamp and back-calculation anti-windup.
module cpi_pi #(
   parameter int unsigned W     = 32,
   parameter int unsigned F     = 16,
   parameter bit          ROUND = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic signed [W-1:0] setp,
   input  logic signed [W-1:0] fbk,
   input  logic signed [W-1:0] kp,
   input  logic signed [W-1:0] ki,
   input  logic signed [W-1:0] kc,
   input  logic signed [W-1:0] lo,
   input  logic signed [W-1:0] hi,
   output logic signed [W-1:0] y
);
   localparam int unsigned SW = W + 2;
   localparam logic signed [SW-1:0] SMAX = (SW'(1) <<< (W-1)) - SW'(1);
   localparam logic signed [SW-1:0] SMIN = -SMAX - SW'(1);

   function automatic logic signed [W-1:0] sat_w(input logic signed [SW-1:0] x);
      if (x > SMAX)      return SMAX[W-1:0];
      else if (x < SMIN) return SMIN[W-1:0];
      else               return x[W-1:0];
   endfunction

   logic signed [W-1:0] acc;
   logic signed [W-1:0] err, pterm, iterm, cterm, raw, clip, diff, acc_n;

   always_comb begin
      err = sat_w(SW'(setp) - SW'(fbk));
   end

   cpi_qmul #(.AW(W), .BW(W), .W(W), .F(F), .ROUND(ROUND)) u_mp (.a(kp), .b(err),  .p(pterm));
   cpi_qmul #(.AW(W), .BW(W), .W(W), .F(F), .ROUND(ROUND)) u_mi (.a(ki), .b(err),  .p(iterm));
   cpi_qmul #(.AW(W), .BW(W), .W(W), .F(F), .ROUND(ROUND)) u_mc (.a(kc), .b(diff), .p(cterm));

   always_comb begin
      raw = sat_w(SW'(pterm) + SW'(acc));
      if (raw > hi)      clip = hi;
      else if (raw < lo) clip = lo;
      else               clip = raw;
      diff  = sat_w(SW'(clip) - SW'(raw));
      acc_n = sat_w(SW'(acc) + SW'(iterm) + SW'(cterm));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc <= '0;
         y   <= '0;
      end else if (en) begin
         acc <= acc_n;
         y   <= clip;
      end
   end
endmodule

// File: rtl/cpi_cascade.sv
module cpi_cascade #(
   parameter int unsigned W     = cpi_pkg::CPI_W_DFLT,
   parameter int unsigned F     = cpi_pkg::CPI_F_DFLT,
   parameter int unsigned DEC   = cpi_pkg::CPI_DEC_DFLT,
   parameter bit          ROUND = cpi_pkg::CPI_RND_DFLT
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_stb,
   input  logic signed [W-1:0] v_ref,
   input  logic signed [W-1:0] v_fb,
   input  logic signed [W-1:0] i_fb,
   input  logic signed [W-1:0] v_kp,
   input  logic signed [W-1:0] v_ki,
   input  logic signed [W-1:0] v_kc,
   input  logic signed [W-1:0] v_lo,
   input  logic signed [W-1:0] v_hi,
   input  logic signed [W-1:0] i_kp,
   input  logic signed [W-1:0] i_ki,
   input  logic signed [W-1:0] i_kc,
   input  logic signed [W-1:0] i_lo,
   input  logic signed [W-1:0] i_hi,
   output logic signed [W-1:0] duty,
   output logic                duty_vld
);
   generate
      if (W < 8 || W > 62) begin : g_bad_w
         $error("cpi_cascade: W out of range");
      end
      if (F < 1 || F >= W) begin : g_bad_f
         $error("cpi_cascade: F must lie in 1..W-1");
      end
      if (DEC < 2) begin : g_bad_dec
         $error("cpi_cascade: DEC must be at least 2");
      end
   endgenerate

   logic                outer_en;
   logic                stb_d;
   logic signed [W-1:0] ifb_q;
   logic signed [W-1:0] vref_hold;

   cpi_decim #(.DEC(DEC)) u_decim (
      .clk(clk), .rst(rst), .stb(smp_stb), .fire(outer_en)
   );

   cpi_pi #(.W(W), .F(F), .ROUND(ROUND)) u_outer (
      .clk(clk), .rst(rst), .en(outer_en),
      .setp(v_ref), .fbk(v_fb),
      .kp(v_kp), .ki(v_ki), .kc(v_kc), .lo(v_lo), .hi(v_hi),
      .y(vref_hold)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         stb_d    <= 1'b0;
         ifb_q    <= '0;
         duty_vld <= 1'b0;
      end else begin
         stb_d    <= smp_stb;
         duty_vld <= stb_d;
         if (smp_stb) ifb_q <= i_fb;
      end
   end

   cpi_pi #(.W(W), .F(F), .ROUND(ROUND)) u_inner (
      .clk(clk), .rst(rst), .en(stb_d),
      .setp(vref_hold), .fbk(ifb_q),
      .kp(i_kp), .ki(i_ki), .kc(i_kc), .lo(i_lo), .hi(i_hi),
      .y(duty)
   );
endmodule

// File: rtl/cpi_cascade_chk.sv
module cpi_cascade_chk #(
   parameter int unsigned W = 32
) (
   input logic                clk,
   input logic                rst,
   input logic                smp_stb,
   input logic                duty_vld,
   input logic signed [W-1:0] duty,
   input logic signed [W-1:0] i_lo,
   input logic signed [W-1:0] i_hi,
   input logic signed [W-1:0] v_lo,
   input logic signed [W-1:0] v_hi,
   input logic                outer_en,
   input logic signed [W-1:0] vref_hold
);
   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (duty == '0 && !duty_vld));

   p_vld_timing_r2: assert property (@(posedge clk) disable iff (rst)
      duty_vld |-> $past(smp_stb, 2));

   p_duty_clamped_r5: assert property (@(posedge clk) disable iff (rst)
      duty_vld |-> (duty >= i_lo && duty <= i_hi));

   p_outer_on_strobe_r7: assert property (@(posedge clk) disable iff (rst)
      outer_en |-> smp_stb);

   p_setp_held_r7: assert property (@(posedge clk) disable iff (rst)
      !outer_en |=> $stable(vref_hold));

   p_setp_clamped_r8: assert property (@(posedge clk) disable iff (rst)
      $past(outer_en) |-> (vref_hold >= v_lo && vref_hold <= v_hi));

   p_duty_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !$stable(duty) |-> duty_vld);
endmodule

bind cpi_cascade cpi_cascade_chk #(.W(W)) u_chk (
   .clk(clk), .rst(rst), .smp_stb(smp_stb), .duty_vld(duty_vld), .duty(duty),
   .i_lo(i_lo), .i_hi(i_hi), .v_lo(v_lo), .v_hi(v_hi),
   .outer_en(outer_en), .vref_hold(vref_hold)
);

// File: tb/cpi_cascade_bench.sv
module cpi_cascade_bench;
   localparam int W = 32;
   localparam longint ONE  = 65536;
   localparam longint MAXV = 64'sd2147483647;
   localparam longint MINV = -64'sd2147483648;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic smp_stb = 1'b0;
   logic signed [W-1:0] v_ref = '0, v_fb = '0, i_fb = '0;
   logic signed [W-1:0] v_kp = '0, v_ki = '0, v_kc = '0, v_lo = '0, v_hi = '0;
   logic signed [W-1:0] i_kp = '0, i_ki = '0, i_kc = '0, i_lo = '0, i_hi = '0;
   logic signed [W-1:0] duty;
   logic duty_vld;

   int checks = 0;
   int errors = 0;

   longint m_vint = 0, m_iint = 0, m_vh = 0;
   int     m_cnt = 0;

   always #10 clk = ~clk;

   cpi_cascade u_cpi_cascade (
      .clk(clk), .rst(rst), .smp_stb(smp_stb),
      .v_ref(v_ref), .v_fb(v_fb), .i_fb(i_fb),
      .v_kp(v_kp), .v_ki(v_ki), .v_kc(v_kc), .v_lo(v_lo), .v_hi(v_hi),
      .i_kp(i_kp), .i_ki(i_ki), .i_kc(i_kc), .i_lo(i_lo), .i_hi(i_hi),
      .duty(duty), .duty_vld(duty_vld)
   );

   function automatic longint sat32(longint x);
      if (x > MAXV) return MAXV;
      if (x < MINV) return MINV;
      return x;
   endfunction

   function automatic longint qm(longint a, longint b);
      return sat32((a * b + 32768) >>> 16);
   endfunction

   function automatic longint pi_step(longint r, longint f, longint kp, longint ki,
                                      longint kc, longint lo, longint hi,
                                      inout longint acc);
      longint e, raw, o, d;
      e   = sat32(r - f);
      raw = sat32(qm(kp, e) + acc);
      o   = (raw > hi) ? hi : ((raw < lo) ? lo : raw);
      d   = sat32(o - raw);
      acc = sat32(acc + qm(ki, e) + qm(kc, d));
      return o;
   endfunction

   task automatic chk(string req, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_vint = 0; m_iint = 0; m_vh = 0; m_cnt = 0;
   endtask

   // one strobe; predicted duty checked in the valid cycle
   task automatic pulse(string req);
      longint exp;
      if (m_cnt == 0)
         m_vh = pi_step(longint'(v_ref), longint'(v_fb), longint'(v_kp), longint'(v_ki),
                        longint'(v_kc), longint'(v_lo), longint'(v_hi), m_vint);
      m_cnt = (m_cnt + 1) % 8;
      exp = pi_step(m_vh, longint'(i_fb), longint'(i_kp), longint'(i_ki),
                    longint'(i_kc), longint'(i_lo), longint'(i_hi), m_iint);
      @(negedge clk); smp_stb = 1'b1;
      @(negedge clk); smp_stb = 1'b0;
      chk({req, " R2 vld low one cycle after strobe"}, longint'(duty_vld), 0);
      @(negedge clk);
      chk({req, " R2 vld high"}, longint'(duty_vld), 1);
      chk({req, " duty"}, longint'(duty), exp);
   endtask

   task automatic set_wide_limits();
      v_lo = W'(MINV); v_hi = W'(MAXV);
      i_lo = W'(MINV); i_hi = W'(MAXV);
   endtask

   task automatic t_reset();
      chk("R1 duty after reset", longint'(duty), 0);
      chk("R1 vld after reset", longint'(duty_vld), 0);
   endtask

   task automatic t_prop();
      set_wide_limits();
      v_kp = W'(ONE); v_ki = '0; v_kc = '0;
      i_kp = W'(ONE / 2); i_ki = '0; i_kc = '0;
      v_ref = 1000; v_fb = 499; i_fb = 0;
      pulse("R3 R8 odd error rounds half up");
      v_fb = -250; i_fb = 100;
      pulse("R3 held setpoint, new current");
      i_fb = -2001;
      pulse("R3 negative-side error");
   endtask

   task automatic t_integ();
      do_reset();
      set_wide_limits();
      v_kp = W'(ONE); v_ki = '0; v_kc = '0;
      i_kp = '0; i_ki = W'(ONE / 4); i_kc = '0;
      v_ref = 400; v_fb = 0; i_fb = 0;
      pulse("R4 first update uses cleared integrator");
      pulse("R4 second update");
      i_fb = 600;
      pulse("R4 negative error reduces integrator");
   endtask

   task automatic t_clamp();
      do_reset();
      v_lo = W'(MINV); v_hi = W'(MAXV);
      i_lo = -50; i_hi = 1000;
      v_kp = W'(ONE); v_ki = '0; v_kc = '0;
      i_kp = W'(ONE); i_ki = W'(ONE / 2); i_kc = W'(ONE);
      v_ref = 5000; v_fb = 0; i_fb = 0;
      for (int k = 0; k < 4; k++) pulse("R5 R6 upper clamp with back-calculation");
      i_fb = 5200;
      pulse("R6 recovery after windup");
      pulse("R5 lower clamp");
   endtask

   task automatic t_outer_clamp();
      do_reset();
      v_lo = 0; v_hi = 300;
      i_lo = W'(MINV); i_hi = W'(MAXV);
      v_kp = W'(ONE); v_ki = '0; v_kc = '0;
      i_kp = W'(ONE); i_ki = '0; i_kc = '0;
      v_ref = 900; v_fb = 0; i_fb = 0;
      pulse("R8 inner setpoint is clamped outer result");
   endtask

   task automatic t_decim();
      do_reset();
      set_wide_limits();
      v_kp = W'(ONE); v_ki = W'(ONE / 8); v_kc = '0;
      i_kp = W'(ONE); i_ki = '0; i_kc = '0;
      v_ref = 800; i_fb = 0;
      for (int k = 0; k < 18; k++) begin
         v_fb = W'(k * 17);
         pulse("R7 decimated outer update");
      end
   endtask

   task automatic t_sat();
      do_reset();
      set_wide_limits();
      v_kp = W'(ONE); v_ki = '0; v_kc = '0;
      i_kp = 32'sh7FFF_0000; i_ki = '0; i_kc = '0;
      v_ref = 100000; v_fb = 0; i_fb = 0;
      pulse("R9 positive saturation");
      chk("R9 positive limit", longint'(duty), MAXV);
      do_reset();
      v_ref = -100000;
      pulse("R9 negative saturation");
      chk("R9 negative limit", longint'(duty), MINV);
   endtask

   task automatic t_hold();
      longint keep;
      do_reset();
      set_wide_limits();
      v_kp = W'(ONE); v_ki = '0; v_kc = '0;
      i_kp = W'(ONE); i_ki = W'(ONE / 4); i_kc = '0;
      v_ref = 300; v_fb = 0; i_fb = 20;
      pulse("R10 setup");
      keep = longint'(duty);
      i_fb = 999; v_fb = 777; v_ref = -5;
      repeat (6) @(negedge clk);
      chk("R10 duty held without strobe", longint'(duty), keep);
      chk("R10 vld stays low", longint'(duty_vld), 0);
      v_ref = 300; v_fb = 0;
      pulse("R10 next update from unchanged integrator");
   endtask

   task automatic t_reset_mid();
      set_wide_limits();
      v_kp = W'(ONE); v_ki = W'(ONE / 2); v_kc = '0;
      i_kp = '0; i_ki = W'(ONE); i_kc = '0;
      v_ref = 100; v_fb = 0; i_fb = 0;
      pulse("R1 build state");
      pulse("R1 build state");
      do_reset();
      @(negedge clk);
      chk("R1 duty cleared mid-run", longint'(duty), 0);
      pulse("R1 fresh integrators after reset");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R2 watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_prop();
      t_integ();
      t_clamp();
      t_outer_clamp();
      t_decim();
      t_sat();
      t_hold();
      t_reset_mid();
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule